// File: doc/BRIEF.md
# Indirect SPI Flash Command Sequencer

This block runs one serial-flash transaction each time software asks for it. Software first loads several registers over a simple 32-bit register bus: an opcode, a flash address, a phase configuration word, and up to sixteen bytes of outgoing data. The configuration word gives, for every phase, a size and a lane width of one, two or four lines. Software then sets the start bit. The engine drives the serial clock, one of four active-low chip selects and four IO lines. It walks through the phases that have a nonzero size and collects up to sixteen incoming bytes. When the transaction ends it clears the start bit.

A chip-select hold mode keeps the chosen device selected between executions. This lets software join several executions into one long flash transaction, for example an opcode and address in the first execution and data in the following ones. The IO pins appear as separate output, output-enable and input vectors, so the pad ring can build the bidirectional buffers.

Top module: `spi_uma_engine`

## Requirements
- R1: When started, the engine runs the phases in the fixed order opcode, address, dummy, outgoing data, incoming data. A phase whose size is zero gets no clock edges.
- R2: Configuration word (word index 0) field layout: opcode enable in bit 10, address byte count in 13:11, dummy byte count in 23:21, outgoing byte count in 20:16, incoming byte count in 28:24. The lane-width codes are in 1:0 (opcode), 3:2 (address), 7:6 (dummy), 5:4 (outgoing) and 9:8 (incoming). The whole word reads back as written.
- R3: Lane-width code 0 uses one lane, code 1 uses two and code 2 uses four. Code 3 behaves as four. Bits go out MSB first. One lane drives IO0 and samples IO1. Two lanes use IO1:IO0 and four lanes use IO3:IO0, with the higher-order bits on the higher-numbered line.
- R4: The opcode phase sends bits 7:0 of the opcode register (index 2). The address phase sends the low N bytes of the address register (index 3), most significant of those bytes first, where N is the address count. A count above 4 is treated as 4.
- R5: Outgoing bytes come from the data-out registers (indices 4 to 7). Incoming bytes land in the data-in registers (indices 8 to 11, read only). Byte k sits in register k/4 at bits 8*(k%4)+7 down to 8*(k%4). Counts above 16 are treated as 16.
- R6: The dummy phase lasts dummy_bytes*8/lanes clock periods. io_oe is 0 during the dummy and incoming phases, and it matches the active lanes during the outgoing phases.
- R7: The control register is word index 1. Writing 1 to its bit 0 starts a transaction. That bit reads 1 while the engine is busy and returns to 0 exactly 4*B+1 cycles after the starting write edge, where B is the total number of serial clock periods. Bit 24 reads 1 when the engine is idle.
- R8: The serial clock runs at the system clock divided by 4, in SPI mode 0. Each period is two cycles low and then two cycles high. The clock idles low.
- R9: The control field in bits 9:8 picks which of the four chip selects is used. No more than one chip select is ever low.
- R10: Control bit 16 is the auto-select bit and resets to 1. When it is 1, the chosen chip select is low only while busy. When it is 0, the chosen chip select stays low while idle and between executions.
- R11: While a transaction runs, bus writes to any register are ignored.
- R12: After reset the configuration word reads 0 and the control register reads 32'h0101_0000. All chip selects are high, the serial clock is low and no IO line is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| sclk | output | 1 | Serial clock to flash |
| cs_n | output | 4 | Active-low chip selects |
| io_out | output | 4 | IO line output values |
| io_oe | output | 4 | IO line output enables |
| io_in | input | 4 | IO line input values |

## Verification
The assertions assume that reset is asserted before the first edge and that bus writes are single-cycle strobes with stable address and data. They also assume io_in matters only in the incoming phase, so the pad inputs may hold any value at other times. The bench drives every bus input on the falling clock edge and holds each strobe for exactly one cycle. Its flash model drives io_in only during the incoming-phase window it works out from the configuration word, and drives zeros elsewhere. Writes during a transaction are placed well inside a long read, so the ignore rule is exercised while the engine is certainly busy.

// File: rtl/spi_uma_engine.sv
module spi_uma_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic [3:0]  cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);

  localparam logic [2:0] P_IDLE = 3'd0;
  localparam logic [2:0] P_CMD  = 3'd1;
  localparam logic [2:0] P_ADR  = 3'd2;
  localparam logic [2:0] P_DUM  = 3'd3;
  localparam logic [2:0] P_WR   = 3'd4;
  localparam logic [2:0] P_RD   = 3'd5;

  logic [31:0]       cfg, adr;
  logic [7:0]        opc;
  logic [3:0][31:0]  wd;
  logic [15:0][7:0]  rb;
  logic [1:0]        dev;
  logic              swcs, busy;
  logic [2:0]        phase, nxt;
  logic [6:0]        beat;
  logic [1:0]        div;

  function automatic logic [1:0] lanes(input logic [1:0] f);
    return f[1] ? 2'd2 : {1'b0, f[0]};
  endfunction

  function automatic logic [7:0] nbeats(input logic [4:0] b, input logic [1:0] w);
    return {b, 3'b000} >> w;
  endfunction

  logic [1:0] lw_c, lw_a, lw_d, lw_w, lw_r, cur_w;
  logic [2:0] asz_c;
  logic [4:0] wsz_c, rsz_c;

  assign lw_c  = lanes(cfg[1:0]);
  assign lw_a  = lanes(cfg[3:2]);
  assign lw_w  = lanes(cfg[5:4]);
  assign lw_d  = lanes(cfg[7:6]);
  assign lw_r  = lanes(cfg[9:8]);
  assign asz_c = (cfg[13:11] > 3'd4)  ? 3'd4  : cfg[13:11];
  assign wsz_c = (cfg[20:16] > 5'd16) ? 5'd16 : cfg[20:16];
  assign rsz_c = (cfg[28:24] > 5'd16) ? 5'd16 : cfg[28:24];

  logic [7:0] plen [8];
  always_comb begin
    plen[0] = 8'd0;
    plen[1] = nbeats({4'b0, cfg[10]}, lw_c);
    plen[2] = nbeats({2'b0, asz_c}, lw_a);
    plen[3] = nbeats({2'b0, cfg[23:21]}, lw_d);
    plen[4] = nbeats(wsz_c, lw_w);
    plen[5] = nbeats(rsz_c, lw_r);
    plen[6] = 8'd0;
    plen[7] = 8'd0;
  end

  always_comb begin
    nxt = P_IDLE;
    for (int p = 5; p >= 1; p--)
      if (3'(p) > phase && plen[p] != 8'd0) nxt = 3'(p);
  end

  always_comb begin
    case (phase)
      P_CMD:   cur_w = lw_c;
      P_ADR:   cur_w = lw_a;
      P_DUM:   cur_w = lw_d;
      P_WR:    cur_w = lw_w;
      default: cur_w = lw_r;
    endcase
  end

  logic [6:0]   bitpos;
  logic [3:0]   bidx;
  logic [2:0]   asel;
  logic [31:0]  ash;
  logic [127:0] wflat, rflat;
  logic [7:0]   txb, sh;
  logic         tx_ph, last_beat;

  assign bitpos    = beat << cur_w;
  assign bidx      = bitpos[6:3];
  assign asel      = asz_c - 3'd1 - bidx[2:0];
  assign ash       = adr >> {asel, 3'b000};
  assign wflat     = wd;
  assign rflat     = rb;
  assign tx_ph     = busy && (phase == P_CMD || phase == P_ADR || phase == P_WR);
  assign last_beat = ({1'b0, beat} == plen[phase] - 8'd1);

  always_comb begin
    case (phase)
      P_CMD:   txb = opc;
      P_ADR:   txb = ash[7:0];
      default: txb = wflat[{bidx, 3'b000} +: 8];
    endcase
  end

  assign sh = txb << bitpos[2:0];

  always_comb begin
    io_out = 4'b0;
    io_oe  = 4'b0;
    if (tx_ph) begin
      case (cur_w)
        2'd0:    begin io_out = {3'b0, sh[7]};   io_oe = 4'b0001; end
        2'd1:    begin io_out = {2'b0, sh[7:6]}; io_oe = 4'b0011; end
        default: begin io_out = sh[7:4];         io_oe = 4'b1111; end
      endcase
    end
  end

  assign sclk = busy && (phase != P_IDLE) && div[1];

  always_comb begin
    cs_n = 4'hF;
    if (busy || !swcs) cs_n[dev] = 1'b0;
  end

  always_comb begin
    case (bus_addr)
      4'd0:                    bus_rdata = cfg;
      4'd1:                    bus_rdata = {7'b0, ~busy, 7'b0, swcs, 6'b0, dev, 7'b0, busy};
      4'd2:                    bus_rdata = {24'b0, opc};
      4'd3:                    bus_rdata = adr;
      4'd4, 4'd5, 4'd6, 4'd7:  bus_rdata = wd[bus_addr[1:0]];
      4'd8, 4'd9, 4'd10, 4'd11: bus_rdata = rflat[{bus_addr[1:0], 5'b00000} +: 32];
      default:                 bus_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= 32'b0;
      adr   <= 32'b0;
      opc   <= 8'b0;
      wd    <= '0;
      rb    <= '0;
      dev   <= 2'b0;
      swcs  <= 1'b1;
      busy  <= 1'b0;
      phase <= P_IDLE;
      beat  <= 7'b0;
      div   <= 2'b0;
    end else if (!busy) begin
      if (bus_wr) begin
        case (bus_addr)
          4'd0: cfg <= bus_wdata;
          4'd1: begin
            dev  <= bus_wdata[9:8];
            swcs <= bus_wdata[16];
            if (bus_wdata[0]) begin
              busy  <= 1'b1;
              phase <= nxt;
              beat  <= 7'b0;
              div   <= 2'b0;
            end
          end
          4'd2: opc <= bus_wdata[7:0];
          4'd3: adr <= bus_wdata;
          4'd4, 4'd5, 4'd6, 4'd7: wd[bus_addr[1:0]] <= bus_wdata;
          default: ;
        endcase
      end
    end else if (phase == P_IDLE) begin
      busy <= 1'b0;
    end else begin
      div <= div + 2'd1;
      if (phase == P_RD && div == 2'd1) begin
        case (cur_w)
          2'd0:    rb[bidx] <= {rb[bidx][6:0], io_in[1]};
          2'd1:    rb[bidx] <= {rb[bidx][5:0], io_in[1:0]};
          default: rb[bidx] <= {rb[bidx][3:0], io_in[3:0]};
        endcase
      end
      if (div == 2'd3) begin
        if (last_beat) begin
          phase <= nxt;
          beat  <= 7'b0;
        end else begin
          beat <= beat + 7'd1;
        end
      end
    end
  end

endmodule

// File: rtl/uma_engine_chk.sv
module uma_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [2:0] phase,
  input logic       sclk,
  input logic [3:0] cs_n,
  input logic [3:0] io_oe,
  input logic [1:0] dev,
  input logic       swcs,
  input logic [31:0] cfg
);

  // R8
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk);

  // R8
  sclk_high_two_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |=> sclk);

  // R9
  single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1);

  // R10
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !cs_n[dev]);

  // R10
  held_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !swcs |-> !cs_n[dev]);

  // R6
  quiet_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (phase == 3'd3 || phase == 3'd5)) |-> io_oe == 4'b0);

  // R1
  phase_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && phase != $past(phase) && phase != 3'd0) |-> phase > $past(phase));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == 3'd0) |=> !busy);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(cfg));

endmodule

bind spi_uma_engine uma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .phase(phase), .sclk(sclk),
  .cs_n(cs_n), .io_oe(io_oe), .dev(dev), .swcs(swcs), .cfg(cfg)
);

// File: tb/tb_spi_uma_engine.sv
`timescale 1ns/1ps
module tb_spi_uma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        sclk;
  logic [3:0]  cs_n, io_out, io_oe, io_in;

  spi_uma_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // flash model: records every rising serial clock edge, serves read bits
  int          ecnt = 0;
  logic [3:0]  rec_out [512];
  logic [3:0]  rec_oe  [512];
  logic [3:0]  rec_cs  [512];
  logic [127:0] rpat = '0;
  int          rpre = 0, rbeats = 0, rcode = 0;
  int          rbit;
  logic [7:0]  rbyte;

  always @(posedge sclk) begin
    if (ecnt < 512) begin
      rec_out[ecnt] = io_out;
      rec_oe[ecnt]  = io_oe;
      rec_cs[ecnt]  = cs_n;
    end
    ecnt = ecnt + 1;
  end

  always_comb begin
    io_in = 4'b0;
    rbit  = 0;
    rbyte = 8'b0;
    if (ecnt >= rpre && ecnt < rpre + rbeats) begin
      rbit  = (ecnt - rpre) << rcode;
      rbyte = rpat[(rbit / 8) * 8 +: 8] << (rbit % 8);
      case (rcode)
        0:       io_in[1]   = rbyte[7];
        1:       io_in[1:0] = rbyte[7:6];
        default: io_in      = rbyte[7:4];
      endcase
    end
  end

  // stimulus and expected-result table: config, opcode, address, device, clock periods
  localparam int NV = 9;
  localparam logic [31:0] V_CFG [NV] = '{32'h0000_0400, 32'h0500_1C00, 32'h1060_1E88,
    32'h0008_1C20, 32'h0720_2500, 32'h0204_0210, 32'h1F00_3C00, 32'h0000_0000, 32'h0000_0403};
  localparam logic [7:0]  V_OPC [NV] = '{8'h06, 8'h03, 8'hEB, 8'h32, 8'h3B, 8'h00, 8'h13, 8'h00, 8'h9F};
  localparam logic [31:0] V_ADR [NV] = '{32'h0, 32'h0012_3456, 32'h00AB_CDEF, 32'h0001_0203,
    32'hDEAD_BEEF, 32'h0, 32'h8899_AABB, 32'h0, 32'h0};
  localparam int V_DEV   [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 0};
  localparam int V_BEATS [NV] = '{8, 72, 52, 48, 76, 20, 168, 0, 2};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      rd(4'd1, v);
      if (!v[0] || n > 2000) break;
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int lanecode(input logic [1:0] f);
    return f[1] ? 2 : int'(f[0]);
  endfunction

  function automatic logic [7:0] gbyte(input int s, input int k, input int w);
    logic [7:0] v = 8'b0;
    int bpb = 8 >> w;
    for (int t = 0; t < bpb; t++) begin
      int e = s + k * bpb + t;
      case (w)
        0:       v = {v[6:0], rec_out[e][0]};
        1:       v = {v[5:0], rec_out[e][1:0]};
        default: v = {v[3:0], rec_out[e][3:0]};
      endcase
    end
    return v;
  endfunction

  function automatic logic [3:0] lmask(input int w);
    return (w == 0) ? 4'b0001 : (w == 1) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic run_vec(input int i);
    logic [31:0]  cfg = V_CFG[i];
    logic [127:0] wdv;
    logic [31:0]  v;
    int cw, aw, dw, ww, rw, nc, na, nd, nw, nr, bc, ba, bd, bw, br, btot, n, errs;
    logic [3:0] cs_exp;
    for (int k = 0; k < 16; k++) begin
      wdv[k*8 +: 8]  = 8'(k * 17 + i * 29 + 3);
      rpat[k*8 +: 8] = 8'((k * 37) ^ (i * 91 + 5));
    end
    cw = lanecode(cfg[1:0]); aw = lanecode(cfg[3:2]); ww = lanecode(cfg[5:4]);
    dw = lanecode(cfg[7:6]); rw = lanecode(cfg[9:8]);
    nc = int'(cfg[10]);
    na = (cfg[13:11] > 4) ? 4 : int'(cfg[13:11]);
    nd = int'(cfg[23:21]);
    nw = (cfg[20:16] > 16) ? 16 : int'(cfg[20:16]);
    nr = (cfg[28:24] > 16) ? 16 : int'(cfg[28:24]);
    bc = (nc * 8) >> cw; ba = (na * 8) >> aw; bd = (nd * 8) >> dw;
    bw = (nw * 8) >> ww; br = (nr * 8) >> rw;
    btot = bc + ba + bd + bw + br;
    wr(4'd0, cfg);
    wr(4'd2, {24'b0, V_OPC[i]});
    wr(4'd3, V_ADR[i]);
    for (int k = 0; k < 4; k++) wr(4'(4 + k), wdv[k*32 +: 32]);
    rpre = bc + ba + bd + bw; rbeats = br; rcode = rw; ecnt = 0;
    wr(4'd1, 32'h0001_0001 | (32'(V_DEV[i]) << 8));
    wait_done(n);
    // R7 R2: done latency from table
    chk(n == 4 * V_BEATS[i] + 1, "R7", $sformatf("vec%0d done latency", i), 64'(n), 64'(4 * V_BEATS[i] + 1));
    // R8 R1: number of serial clock periods
    chk(ecnt == btot && btot == V_BEATS[i], "R8", $sformatf("vec%0d clock periods", i), 64'(ecnt), 64'(V_BEATS[i]));
    errs = 0;
    if (nc != 0 && gbyte(0, 0, cw) != V_OPC[i]) errs++;
    for (int k = 0; k < na; k++)
      if (gbyte(bc, k, aw) != V_ADR[i][(na - 1 - k) * 8 +: 8]) errs++;
    // R4 R3: opcode and address bits on the lines
    chk(errs == 0, "R4", $sformatf("vec%0d opcode/address bytes", i), 64'(errs), 64'd0);
    errs = 0;
    for (int k = 0; k < nw; k++)
      if (gbyte(bc + ba + bd, k, ww) != wdv[k*8 +: 8]) errs++;
    // R5 R3: outgoing data bytes
    chk(errs == 0, "R5", $sformatf("vec%0d outgoing bytes", i), 64'(errs), 64'd0);
    errs = 0;
    for (int e = 0; e < btot && e < 512; e++) begin
      logic [3:0] m;
      if (e < bc) m = lmask(cw);
      else if (e < bc + ba) m = lmask(aw);
      else if (e < bc + ba + bd) m = 4'b0;
      else if (e < bc + ba + bd + bw) m = lmask(ww);
      else m = 4'b0;
      if (rec_oe[e] != m) errs++;
    end
    // R6: drive enables per phase, quiet in dummy and incoming
    chk(errs == 0, "R6", $sformatf("vec%0d io_oe per phase", i), 64'(errs), 64'd0);
    cs_exp = 4'hF;
    cs_exp[V_DEV[i]] = 1'b0;
    errs = 0;
    for (int e = 0; e < btot && e < 512; e++) if (rec_cs[e] != cs_exp) errs++;
    // R9: selected device only
    chk(errs == 0, "R9", $sformatf("vec%0d chip select during run", i), 64'(errs), 64'd0);
    // R10: auto-select releases after run
    chk(cs_n == 4'hF, "R10", $sformatf("vec%0d chip select after run", i), 64'(cs_n), 64'hF);
    errs = 0;
    for (int k = 0; k < nr; k++) begin
      rd(4'(8 + k / 4), v);
      if (v[(k % 4) * 8 +: 8] != rpat[k*8 +: 8]) errs++;
    end
    // R5 R3: incoming bytes little-endian in data-in registers
    chk(errs == 0, "R5", $sformatf("vec%0d incoming bytes", i), 64'(errs), 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL R7 watchdog actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    rd(4'd1, v); chk(v == 32'h0101_0000, "R12", "control after reset", 64'(v), 64'h0101_0000);
    rd(4'd0, v); chk(v == 32'h0, "R12", "config after reset", 64'(v), 64'h0);
    chk(cs_n == 4'hF && sclk == 1'b0 && io_oe == 4'h0, "R12", "pins after reset",
        64'({cs_n, 3'b0, sclk, io_oe}), 64'hF00);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: config word reads back as written
    wr(4'd0, 32'hA5A5_5A5A);
    rd(4'd0, v); chk(v == 32'hA5A5_5A5A, "R2", "config readback", 64'(v), 64'hA5A5_5A5A);

    // R11: writes during a long run are ignored
    wr(4'd0, V_CFG[6]);
    wr(4'd4, 32'h1234_5678);
    rbeats = 0; ecnt = 0;
    wr(4'd1, 32'h0001_0201);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0);
    wr(4'd1, 32'h0000_0300);
    wait_done(n);
    rd(4'd0, v); chk(v == V_CFG[6], "R11", "config kept while busy", 64'(v), 64'(V_CFG[6]));
    rd(4'd4, v); chk(v == 32'h1234_5678, "R11", "data-out kept while busy", 64'(v), 64'h1234_5678);
    rd(4'd1, v); chk(v == 32'h0101_0200, "R11", "control kept while busy", 64'(v), 64'h0101_0200);

    // R10: held chip select joins two executions
    wr(4'd1, 32'h0000_0100);
    chk(cs_n == 4'b1101, "R10", "held select while idle", 64'(cs_n), 64'hD);
    wr(4'd0, 32'h0000_1C00);
    wr(4'd2, 32'h02);
    wr(4'd3, 32'h0055_6677);
    ecnt = 0;
    wr(4'd1, 32'h0000_0101);
    wait_done(n);
    chk(cs_n == 4'b1101, "R10", "held select between runs", 64'(cs_n), 64'hD);
    wr(4'd0, 32'h0004_0000);
    wr(4'd4, 32'hC0DE_F00D);
    wr(4'd1, 32'h0000_0101);
    wait_done(n);
    chk(ecnt == 64, "R1", "joined run clock periods", 64'(ecnt), 64'd64);
    chk({gbyte(0, 0, 0), gbyte(8, 0, 0), gbyte(8, 1, 0), gbyte(8, 2, 0)} == 32'h0255_6677,
        "R4", "joined opcode/address", 64'({gbyte(0, 0, 0), gbyte(8, 0, 0), gbyte(8, 1, 0), gbyte(8, 2, 0)}),
        64'h0255_6677);
    chk({gbyte(32, 3, 0), gbyte(32, 2, 0), gbyte(32, 1, 0), gbyte(32, 0, 0)} == 32'hC0DE_F00D,
        "R5", "joined data bytes", 64'({gbyte(32, 3, 0), gbyte(32, 2, 0), gbyte(32, 1, 0), gbyte(32, 0, 0)}),
        64'hC0DE_F00D);
    wr(4'd1, 32'h0001_0100);
    chk(cs_n == 4'hF, "R10", "release after auto-select set", 64'(cs_n), 64'hF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule